// File: doc/BRIEF.md
# Message-Signalled Interrupt to Adapter Interrupt Router

This block terminates message-signalled interrupt writes aimed at a host that has no memory-mapped interrupt controller. Each 32-bit message word is divided into a function id (upper bits) and a vector number (low bits). The id is matched against a small table of functions loaded through a write port. A matching function gets two bits set in memory through a byte-wide atomic OR port: first a per-vector indicator bit and then a per-function summary bit. A host adapter interrupt is raised only when the summary byte held zero before the update. An id that matches no active function produces an error event instead, and no memory access is made.

Bits are numbered from the most significant bit of each byte, so bit number `n` lives in byte `n/8` under mask `8'h80 >> (n%8)`. The block handles one message at a time and holds `msgReady` low until both memory updates have finished. Reads of the message window always return all ones.

Top module: `msi_adapter_router`

## Requirements
- R1: The message word is split so that the vector is `msgData[VEC_W-1:0]` (default 8 bits) and the function id is `msgData >> VEC_W`. A message is accepted on a rising clock edge where `msgValid` and `msgReady` are both high.
- R2: If no table entry with a nonzero handle holds the id, the block posts one event with `evtCode` 8'h02 (no target), `evtFid` set to the id, `evtAddr` set to `msgAddr`, and `evtQual` set to `vector << 16`. It makes no memory access and raises no interrupt.
- R3: Indicator access: the bit number is the entry's indicator offset plus the vector. The access uses address `indBase + bit/8` and mask `8'h80 >> (bit%8)`.
- R4: Summary access: the address is `sumBase + sumOff/8` and the mask is `8'h80 >> (sumOff%8)`.
- R5: For a matched message there are exactly two atomic OR accesses, the indicator first and then the summary. Each access holds `memReq`, `memAddr` and `memOrMask` steady until `memAck`.
- R6: `irqValid` pulses for one cycle only when the summary access completed without error and returned a prior byte of 8'h00. `irqWord` is `(isc << 27) | 32'h8000_0000`.
- R7: An access acknowledged with `memErr` posts an event with `evtCode` 8'h03 and zero fid, address and qualifier. An indicator error still leads on to the summary access. A summary error suppresses the interrupt.
- R8: A read request is answered one cycle later with `rdAck` high and `rdData` equal to 32'hFFFF_FFFF.
- R9: When several active entries hold the same id, the entry with the lowest index is used. Entries with a zero handle never match.
- R10: `msgReady` is low from the cycle after acceptance until the message has completed.
- R11: Out of reset, `msgReady` is high and `memReq`, `irqValid`, `evtValid` and `rdAck` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | Message write present |
| msgReady | output | 1 | Block can accept a message |
| msgData | input | DATA_W | Message data word (id and vector) |
| msgAddr | input | AW | Window address of the message write |
| rdReq | input | 1 | Read of the message window |
| rdAck | output | 1 | Read response valid |
| rdData | output | DATA_W | Read response (all ones) |
| tblWe | input | 1 | Function table write enable |
| tblIdx | input | IDX_W | Table entry index |
| tblFid | input | FID_W | Function id of the entry |
| tblHandle | input | HDL_W | Handle of the entry; zero means inactive |
| tblIndBase | input | AW | Indicator area byte base |
| tblIndOff | input | OFF_W | Indicator bit offset |
| tblSumBase | input | AW | Summary area byte base |
| tblSumOff | input | OFF_W | Summary bit offset |
| tblIsc | input | ISC_W | Interrupt subclass |
| memReq | output | 1 | Atomic OR request |
| memAddr | output | AW | Byte address of the request |
| memOrMask | output | 8 | Byte mask to OR in |
| memAck | input | 1 | Request completed |
| memOld | input | 8 | Byte value before the OR |
| memErr | input | 1 | Access failed |
| irqValid | output | 1 | Adapter interrupt pulse |
| irqWord | output | 32 | Interruption word |
| evtValid | output | 1 | Error event pulse |
| evtCode | output | 8 | Event code |
| evtFid | output | FID_W | Event function id |
| evtAddr | output | AW | Event address |
| evtQual | output | 32 | Event qualifier |

## Verification
The hardest case to reach is interrupt suppression caused by other bits in the same summary byte. This happens when the summary byte was already nonzero, either because an earlier message set the same bit or because an unrelated bit that shares the byte was set. The stimulus reaches it by giving one function overlapping indicator and summary bytes, so that its own indicator write makes the summary byte nonzero first. It also clears a summary byte in the bench memory mid-run to show that interrupts return. The scoreboard checks the ordering of the memory accesses and of the events. Error paths use an address region that the bench memory acknowledges with an error.

// File: rtl/msi_router_pkg.sv
package msi_router_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_IND  = 2'd2,
    ST_SUM  = 2'd3
  } router_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capMsg;   // latch message word and window address
    logic capHit;   // latch winning table entry
    logic selSum;   // memory port addresses the summary byte
    logic evNoTgt;  // post no-target event
    logic evAir;    // post indicator-access event
    logic fireIrq;  // raise adapter interrupt
  } router_strobe_t;

  localparam logic [7:0]  CODE_NO_TARGET = 8'h02;
  localparam logic [7:0]  CODE_IND_FAIL  = 8'h03;
  localparam logic [31:0] ADAPTER_FLAG   = 32'h8000_0000;
  localparam int          IRQ_ISC_SHIFT  = 27;
  localparam int          QUAL_VEC_SHIFT = 16;

endpackage

// File: rtl/msi_fn_table.sv
module msi_fn_table #(
  parameter int ENTRIES = 32,
  parameter int FID_W   = 24,
  parameter int HDL_W   = 32,
  parameter int AW      = 32,
  parameter int OFF_W   = 16,
  parameter int ISC_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [FID_W-1:0] wrFid,
  input  logic [HDL_W-1:0] wrHandle,
  input  logic [AW-1:0]    wrIndBase,
  input  logic [OFF_W-1:0] wrIndOff,
  input  logic [AW-1:0]    wrSumBase,
  input  logic [OFF_W-1:0] wrSumOff,
  input  logic [ISC_W-1:0] wrIsc,
  input  logic [FID_W-1:0] qFid,
  output logic             hit,
  output logic [AW-1:0]    hitIndBase,
  output logic [OFF_W-1:0] hitIndOff,
  output logic [AW-1:0]    hitSumBase,
  output logic [OFF_W-1:0] hitSumOff,
  output logic [ISC_W-1:0] hitIsc
);

  logic [FID_W-1:0] fidArr     [ENTRIES];
  logic             actArr     [ENTRIES];
  logic [AW-1:0]    indBaseArr [ENTRIES];
  logic [OFF_W-1:0] indOffArr  [ENTRIES];
  logic [AW-1:0]    sumBaseArr [ENTRIES];
  logic [OFF_W-1:0] sumOffArr  [ENTRIES];
  logic [ISC_W-1:0] iscArr     [ENTRIES];
  logic [ENTRIES-1:0] matchVec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        actArr[g]     <= 1'b0;
        fidArr[g]     <= '0;
        indBaseArr[g] <= '0;
        indOffArr[g]  <= '0;
        sumBaseArr[g] <= '0;
        sumOffArr[g]  <= '0;
        iscArr[g]     <= '0;
      end else if (wrEn && wrIdx == IDX_W'(g)) begin
        actArr[g]     <= (wrHandle != '0);
        fidArr[g]     <= wrFid;
        indBaseArr[g] <= wrIndBase;
        indOffArr[g]  <= wrIndOff;
        sumBaseArr[g] <= wrSumBase;
        sumOffArr[g]  <= wrSumOff;
        iscArr[g]     <= wrIsc;
      end
    end
    assign matchVec[g] = actArr[g] && (fidArr[g] == qFid);
  end

  // priority select: walking downward leaves the lowest match
  always_comb begin
    hit        = 1'b0;
    hitIndBase = '0;
    hitIndOff  = '0;
    hitSumBase = '0;
    hitSumOff  = '0;
    hitIsc     = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hit        = 1'b1;
        hitIndBase = indBaseArr[i];
        hitIndOff  = indOffArr[i];
        hitSumBase = sumBaseArr[i];
        hitSumOff  = sumOffArr[i];
        hitIsc     = iscArr[i];
      end
    end
  end

  p_hit_has_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (matchVec != '0));

endmodule

// File: rtl/msi_router_ctrl.sv
module msi_router_ctrl
  import msi_router_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           msgValid,
  input  logic           hit,
  input  logic           memAck,
  input  logic           memErr,
  input  logic           memOldZero,
  output logic           msgReady,
  output logic           memReq,
  output router_strobe_t strb
);

  router_state_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    msgReady = 1'b0;
    memReq   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        msgReady = 1'b1;
        if (msgValid) begin
          strb.capMsg = 1'b1;
          stateNxt    = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (hit) begin
          strb.capHit = 1'b1;
          stateNxt    = ST_IND;
        end else begin
          strb.evNoTgt = 1'b1;
          stateNxt     = ST_IDLE;
        end
      end
      ST_IND: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.evAir = memErr;
          stateNxt   = ST_SUM;
        end
      end
      ST_SUM: begin
        memReq      = 1'b1;
        strb.selSum = 1'b1;
        if (memAck) begin
          strb.evAir   = memErr;
          strb.fireIrq = !memErr && memOldZero;
          stateNxt     = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> !msgReady);

  p_miss_no_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOK && !hit) |=> !memReq);

  p_err_no_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.evAir && strb.fireIrq));

  p_ind_then_sum_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !strb.selSum && memAck) |=> (memReq && strb.selSum));

endmodule

// File: rtl/msi_router_dp.sv
module msi_router_dp
  import msi_router_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  parameter int AW     = 32,
  parameter int OFF_W  = 16,
  parameter int ISC_W  = 3,
  localparam int FID_W = DATA_W - VEC_W,
  localparam int BIT_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  router_strobe_t    strb,
  input  logic [DATA_W-1:0] msgData,
  input  logic [AW-1:0]     msgAddr,
  input  logic [AW-1:0]     entIndBase,
  input  logic [OFF_W-1:0]  entIndOff,
  input  logic [AW-1:0]     entSumBase,
  input  logic [OFF_W-1:0]  entSumOff,
  input  logic [ISC_W-1:0]  entIsc,
  input  logic              memReq,
  input  logic              memAck,
  input  logic [7:0]        memOld,
  input  logic              memErr,
  input  logic              rdReq,
  output logic [FID_W-1:0]  lookFid,
  output logic [AW-1:0]     memAddr,
  output logic [7:0]        memOrMask,
  output logic              memOldZero,
  output logic              rdAck,
  output logic [DATA_W-1:0] rdData,
  output logic              irqValid,
  output logic [31:0]       irqWord,
  output logic              evtValid,
  output logic [7:0]        evtCode,
  output logic [FID_W-1:0]  evtFid,
  output logic [AW-1:0]     evtAddr,
  output logic [31:0]       evtQual
);

  logic [FID_W-1:0] fidQ;
  logic [VEC_W-1:0] vecQ;
  logic [AW-1:0]    winAddrQ;
  logic [AW-1:0]    indBaseQ, sumBaseQ;
  logic [OFF_W-1:0] indOffQ, sumOffQ;
  logic [ISC_W-1:0] iscQ;
  logic [BIT_W-1:0] indBit;
  logic [AW-1:0]    indAddr, sumAddr;
  logic [7:0]       indMask, sumMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fidQ     <= '0;
      vecQ     <= '0;
      winAddrQ <= '0;
    end else if (strb.capMsg) begin
      fidQ     <= msgData[DATA_W-1:VEC_W];
      vecQ     <= msgData[VEC_W-1:0];
      winAddrQ <= msgAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indBaseQ <= '0;
      indOffQ  <= '0;
      sumBaseQ <= '0;
      sumOffQ  <= '0;
      iscQ     <= '0;
    end else if (strb.capHit) begin
      indBaseQ <= entIndBase;
      indOffQ  <= entIndOff;
      sumBaseQ <= entSumBase;
      sumOffQ  <= entSumOff;
      iscQ     <= entIsc;
    end
  end

  assign lookFid = fidQ;

  // MSB-first bit numbering inside each byte
  assign indBit     = {1'b0, indOffQ} + BIT_W'(vecQ);
  assign indAddr    = indBaseQ + AW'(indBit >> 3);
  assign indMask    = 8'h80 >> indBit[2:0];
  assign sumAddr    = sumBaseQ + AW'(sumOffQ >> 3);
  assign sumMask    = 8'h80 >> sumOffQ[2:0];
  assign memAddr    = strb.selSum ? sumAddr : indAddr;
  assign memOrMask  = strb.selSum ? sumMask : indMask;
  assign memOldZero = (memOld == 8'h00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqValid <= 1'b0;
      irqWord  <= '0;
      evtValid <= 1'b0;
      evtCode  <= '0;
      evtFid   <= '0;
      evtAddr  <= '0;
      evtQual  <= '0;
      rdAck    <= 1'b0;
      rdData   <= '0;
    end else begin
      irqValid <= strb.fireIrq;
      if (strb.fireIrq)
        irqWord <= (32'(iscQ) << IRQ_ISC_SHIFT) | ADAPTER_FLAG;
      evtValid <= strb.evNoTgt || strb.evAir;
      if (strb.evNoTgt) begin
        evtCode <= CODE_NO_TARGET;
        evtFid  <= fidQ;
        evtAddr <= winAddrQ;
        evtQual <= 32'(vecQ) << QUAL_VEC_SHIFT;
      end else if (strb.evAir) begin
        evtCode <= CODE_IND_FAIL;
        evtFid  <= '0;
        evtAddr <= '0;
        evtQual <= '0;
      end
      rdAck  <= rdReq;
      rdData <= rdReq ? '1 : '0;
    end
  end

  p_irq_needs_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ($past(memAck) && !$past(memErr) && $past(memOld) == 8'h00));

  p_single_bit_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ($countones(memOrMask) == 1));

  p_req_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memOrMask)));

  p_read_ones_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> (rdAck && rdData == '1));

endmodule

// File: rtl/msi_adapter_router.sv
module msi_adapter_router
  import msi_router_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 8,
  parameter int ENTRIES = 32,
  parameter int HDL_W   = 32,
  parameter int AW      = 32,
  parameter int OFF_W   = 16,
  parameter int ISC_W   = 3,
  localparam int FID_W  = DATA_W - VEC_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  output logic              msgReady,
  input  logic [DATA_W-1:0] msgData,
  input  logic [AW-1:0]     msgAddr,
  input  logic              rdReq,
  output logic              rdAck,
  output logic [DATA_W-1:0] rdData,
  input  logic              tblWe,
  input  logic [IDX_W-1:0]  tblIdx,
  input  logic [FID_W-1:0]  tblFid,
  input  logic [HDL_W-1:0]  tblHandle,
  input  logic [AW-1:0]     tblIndBase,
  input  logic [OFF_W-1:0]  tblIndOff,
  input  logic [AW-1:0]     tblSumBase,
  input  logic [OFF_W-1:0]  tblSumOff,
  input  logic [ISC_W-1:0]  tblIsc,
  output logic              memReq,
  output logic [AW-1:0]     memAddr,
  output logic [7:0]        memOrMask,
  input  logic              memAck,
  input  logic [7:0]        memOld,
  input  logic              memErr,
  output logic              irqValid,
  output logic [31:0]       irqWord,
  output logic              evtValid,
  output logic [7:0]        evtCode,
  output logic [FID_W-1:0]  evtFid,
  output logic [AW-1:0]     evtAddr,
  output logic [31:0]       evtQual
);

  router_strobe_t   strb;
  logic             hit, memOldZero;
  logic [FID_W-1:0] lookFid;
  logic [AW-1:0]    entIndBase, entSumBase;
  logic [OFF_W-1:0] entIndOff, entSumOff;
  logic [ISC_W-1:0] entIsc;

  msi_fn_table #(
    .ENTRIES(ENTRIES), .FID_W(FID_W), .HDL_W(HDL_W),
    .AW(AW), .OFF_W(OFF_W), .ISC_W(ISC_W)
  ) u_table (
    .clk(clk), .rstN(rstN),
    .wrEn(tblWe), .wrIdx(tblIdx), .wrFid(tblFid), .wrHandle(tblHandle),
    .wrIndBase(tblIndBase), .wrIndOff(tblIndOff),
    .wrSumBase(tblSumBase), .wrSumOff(tblSumOff), .wrIsc(tblIsc),
    .qFid(lookFid), .hit(hit),
    .hitIndBase(entIndBase), .hitIndOff(entIndOff),
    .hitSumBase(entSumBase), .hitSumOff(entSumOff), .hitIsc(entIsc)
  );

  msi_router_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .hit(hit),
    .memAck(memAck), .memErr(memErr), .memOldZero(memOldZero),
    .msgReady(msgReady), .memReq(memReq), .strb(strb)
  );

  msi_router_dp #(
    .DATA_W(DATA_W), .VEC_W(VEC_W), .AW(AW), .OFF_W(OFF_W), .ISC_W(ISC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .msgData(msgData), .msgAddr(msgAddr),
    .entIndBase(entIndBase), .entIndOff(entIndOff),
    .entSumBase(entSumBase), .entSumOff(entSumOff), .entIsc(entIsc),
    .memReq(memReq), .memAck(memAck), .memOld(memOld), .memErr(memErr),
    .rdReq(rdReq), .lookFid(lookFid),
    .memAddr(memAddr), .memOrMask(memOrMask), .memOldZero(memOldZero),
    .rdAck(rdAck), .rdData(rdData),
    .irqValid(irqValid), .irqWord(irqWord),
    .evtValid(evtValid), .evtCode(evtCode), .evtFid(evtFid),
    .evtAddr(evtAddr), .evtQual(evtQual)
  );

endmodule

// File: tb/sim_msi_adapter_router.sv
module sim_msi_adapter_router;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ERR_BASE = 32'hF000_0000;
  localparam int K_MEM = 0, K_IRQ = 1, K_EVT = 2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic [31:0] d;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msgValid = 1'b0;
  logic [31:0] msgData = '0;
  logic [31:0] msgAddr = '0;
  logic rdReq = 1'b0;
  logic tblWe = 1'b0;
  logic [4:0] tblIdx = '0;
  logic [23:0] tblFid = '0;
  logic [31:0] tblHandle = '0;
  logic [31:0] tblIndBase = '0, tblSumBase = '0;
  logic [15:0] tblIndOff = '0, tblSumOff = '0;
  logic [2:0] tblIsc = '0;
  logic memAck = 1'b0;
  logic [7:0] memOld = '0;
  logic memErr = 1'b0;
  logic msgReady, rdAck, memReq, irqValid, evtValid;
  logic [31:0] rdData, memAddr, irqWord, evtAddr, evtQual;
  logic [7:0] memOrMask, evtCode;
  logic [23:0] evtFid;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  exp_t expQ[$];
  logic [7:0] mem [int unsigned];
  logic [7:0] shadow [int unsigned];

  logic [23:0] mFid [32];
  logic [31:0] mHdl [32];
  logic [31:0] mIndBase [32], mSumBase [32];
  logic [15:0] mIndOff [32], mSumOff [32];
  logic [2:0]  mIsc [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_adapter_router u0 (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgReady(msgReady),
    .msgData(msgData), .msgAddr(msgAddr), .rdReq(rdReq), .rdAck(rdAck),
    .rdData(rdData), .tblWe(tblWe), .tblIdx(tblIdx), .tblFid(tblFid),
    .tblHandle(tblHandle), .tblIndBase(tblIndBase), .tblIndOff(tblIndOff),
    .tblSumBase(tblSumBase), .tblSumOff(tblSumOff), .tblIsc(tblIsc),
    .memReq(memReq), .memAddr(memAddr), .memOrMask(memOrMask),
    .memAck(memAck), .memOld(memOld), .memErr(memErr),
    .irqValid(irqValid), .irqWord(irqWord), .evtValid(evtValid),
    .evtCode(evtCode), .evtFid(evtFid), .evtAddr(evtAddr), .evtQual(evtQual)
  );

  function automatic logic [7:0] rdMem(int unsigned adr);
    return mem.exists(adr) ? mem[adr] : 8'h00;
  endfunction
  function automatic logic [7:0] rdShadow(int unsigned adr);
    return shadow.exists(adr) ? shadow[adr] : 8'h00;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic void compareItem(string req, exp_t got);
    exp_t e;
    checks++;
    if (expQ.size() == 0) begin
      fails++;
      $display("FAIL %s actual=%0h expected=none", req, got);
      return;
    end
    e = expQ.pop_front();
    if (got !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, e);
    end
  endfunction

  // monitor and memory responder in one process, so no edge race
  always @(negedge clk) begin
    if (rstN) begin
      if (evtValid)
        compareItem("R2/R7 event", '{K_EVT, 32'(evtCode), 32'(evtFid), evtAddr, evtQual});
      if (irqValid)
        compareItem("R6 interrupt", '{K_IRQ, irqWord, 32'h0, 32'h0, 32'h0});
    end
    if (memAck) begin
      memAck = 1'b0;
      memErr = 1'b0;
    end else if (memReq) begin
      compareItem("R3/R4/R5 access", '{K_MEM, memAddr, 32'(memOrMask), 32'h0, 32'h0});
      memAck = 1'b1;
      if (memAddr >= ERR_BASE) begin
        memErr = 1'b1;
        memOld = 8'h00;
      end else begin
        memErr = 1'b0;
        memOld = rdMem(memAddr);
        mem[memAddr] = memOld | memOrMask;
      end
    end
  end

  task automatic writeEntry(int idx, logic [23:0] fid, logic [31:0] hdl,
                            logic [31:0] ib, logic [15:0] io,
                            logic [31:0] sb, logic [15:0] so, logic [2:0] isc);
    @(negedge clk);
    tblWe = 1'b1; tblIdx = 5'(idx); tblFid = fid; tblHandle = hdl;
    tblIndBase = ib; tblIndOff = io; tblSumBase = sb; tblSumOff = so; tblIsc = isc;
    mFid[idx] = fid; mHdl[idx] = hdl; mIndBase[idx] = ib; mIndOff[idx] = io;
    mSumBase[idx] = sb; mSumOff[idx] = so; mIsc[idx] = isc;
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  // driver: predicts the result items, then drives the message
  task automatic sendMsg(logic [23:0] fid, logic [7:0] vec, logic [31:0] wa);
    int slot = -1;
    for (int i = 31; i >= 0; i--)
      if (mHdl[i] != 0 && mFid[i] == fid) slot = i;
    if (slot < 0) begin
      expQ.push_back('{K_EVT, 32'h02, 32'(fid), wa, 32'(vec) << 16});
    end else begin
      int unsigned bitN = 32'(mIndOff[slot]) + 32'(vec);
      int unsigned ia = mIndBase[slot] + bitN / 8;
      logic [7:0] im = 8'h80 >> (bitN % 8);
      int unsigned sa = mSumBase[slot] + 32'(mSumOff[slot]) / 8;
      logic [7:0] sm = 8'h80 >> (mSumOff[slot] % 8);
      expQ.push_back('{K_MEM, ia, 32'(im), 32'h0, 32'h0});
      if (ia >= ERR_BASE) expQ.push_back('{K_EVT, 32'h03, 32'h0, 32'h0, 32'h0});
      else shadow[ia] = rdShadow(ia) | im;
      expQ.push_back('{K_MEM, sa, 32'(sm), 32'h0, 32'h0});
      if (sa >= ERR_BASE) expQ.push_back('{K_EVT, 32'h03, 32'h0, 32'h0, 32'h0});
      else begin
        logic [7:0] old = rdShadow(sa);
        shadow[sa] = old | sm;
        if (old == 8'h00)
          expQ.push_back('{K_IRQ, (32'(mIsc[slot]) << 27) | 32'h8000_0000, 32'h0, 32'h0, 32'h0});
      end
    end
    @(negedge clk);
    msgValid = 1'b1; msgData = {fid, vec}; msgAddr = wa;
    while (!msgReady) @(negedge clk);
    @(negedge clk);
    msgValid = 1'b0;
    check("R10 ready low while busy", 128'(msgReady), 128'(1'b0));
    while (expQ.size() != 0 || !msgReady) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mHdl[i] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ready", 128'(msgReady), 128'(1'b1));
    check("R11 outputs idle", 128'({memReq, irqValid, evtValid, rdAck}), 128'(4'b0));
    rstN = 1'b1;
    @(negedge clk);

    // R8 read returns all ones
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
    check("R8 read ack", 128'(rdAck), 128'(1'b1));
    check("R8 read data", 128'(rdData), 128'(32'hFFFF_FFFF));

    writeEntry(0, 24'h5, 32'h0, 32'h6000, 16'd0, 32'h6100, 16'd0, 3'd1);   // inactive (R9)
    writeEntry(3, 24'h5, 32'h1, 32'h1000, 16'd3, 32'h2000, 16'd10, 3'd5);
    writeEntry(7, 24'h5, 32'h2, 32'h5000, 16'd0, 32'h5100, 16'd7, 3'd2);
    writeEntry(9, 24'h9, 32'h3, 32'h3000, 16'd0, 32'h3000, 16'd0, 3'd4);
    writeEntry(12, 24'h77, 32'h4, ERR_BASE, 16'd0, 32'h2100, 16'd0, 3'd7);
    writeEntry(13, 24'h78, 32'h5, 32'h4000, 16'd0, ERR_BASE + 32'h10, 16'd0, 3'd6);

    sendMsg(24'h5, 8'd0, 32'h0);        // R1 R3 R4 R6 R9: slot 3, first summary set
    sendMsg(24'h5, 8'd13, 32'h0);       // R6: summary already set, no interrupt
    sendMsg(24'h9, 8'd7, 32'h0);        // R6: shared byte made nonzero by indicator
    sendMsg(24'h99, 8'h3C, 32'h0000_0ABC); // R2 unknown id
    sendMsg(24'h77, 8'd2, 32'h0);       // R7 indicator error, summary still written
    sendMsg(24'h78, 8'd4, 32'h0);       // R7 summary error, no interrupt
    mem[32'h2001] = 8'h00; shadow[32'h2001] = 8'h00;
    sendMsg(24'h5, 8'd255, 32'h0);      // R3 carry into later byte, interrupt returns
    writeEntry(3, 24'h5, 32'h0, 32'h1000, 16'd3, 32'h2000, 16'd10, 3'd5);
    sendMsg(24'h5, 8'd1, 32'h0);        // R9 next lowest active slot (7)

    // R3 R4 final memory image against model
    foreach (shadow[a]) check("R3/R4 memory byte", 128'(rdMem(a)), 128'(shadow[a]));
    check("R5 no stray items", 128'(expQ.size()), 128'(0));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule